// File: doc/BRIEF.md
# Page Write Gather Buffer with Address Pointer

This block sits between a serial-memory protocol engine and a byte-wide nonvolatile array. While a write transfer runs, it collects data bytes into a 32-byte page buffer. The first byte goes to the page offset given by the loaded word address, and later bytes step through the page, wrapping inside it. A per-offset mark records which bytes arrived since the last start condition.

When the engine signals the stop (commit), the block scans the page in ascending offset order. For each marked offset it issues one write on a valid/ready stream toward the array. The producer may stall that stream: `wr_valid` stays high with stable `wr_addr` and `wr_data` until `wr_ready` is seen high at a clock edge. While the scan runs, `in_ready` is low and the block ignores start, address and commit pulses. When the last write completes, the block updates the internal address pointer `ptr` according to the byte count.

Top module: `page_write_buffer`

## Requirements
- R1: A byte accepted (`in_valid` && `in_ready`) is stored at page offset `addr_in[4:0]` of the last loaded address. Each further byte goes to the next offset. `wr_addr[12:5]` always equals the loaded address's bits 12..5.
- R2: Offsets wrap from 31 to 0 inside the page. An offset written more than once is committed with the last byte given to it.
- R3: A commit writes only the marked offsets, one write per `wr_valid`&&`wr_ready` cycle, in ascending offset order. No other location receives a write.
- R4: While `wr_valid` is high and `wr_ready` is low, on the next cycle `wr_valid` is still high and `wr_addr` and `wr_data` are unchanged.
- R5: While `busy` is high, `in_ready` is low, and pulses on `bus_start`, `addr_vld` and `commit` are ignored.
- R6: After a commit of N bytes, with 1 ≤ N ≤ 31, `ptr` equals the loaded address with its offset replaced by (offset + N) mod 32.
- R7: After a commit of 32 or more bytes, `ptr` equals the loaded address.
- R8: A single byte written at offset 31 leaves `ptr` at offset 0 of the same page.
- R9: If `wp` is high in any cycle from `bus_start` up to and including the commit cycle, no array write is issued. `ptr` is still updated per R6/R7.
- R10: A commit with no bytes captured issues no write and sets `ptr` to the loaded address on the commit edge.
- R11: After reset, `ptr` is 0, `wr_valid` is 0, `in_ready` is 1 and `busy` is 0.
- R12: During a flush, `ptr` keeps its old value. It changes on the edge that completes the scan of the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start-condition pulse; clears marks, count and protect history |
| addr_vld | input | 1 | Loads `addr_in` as the word address |
| addr_in | input | 13 | Word address |
| in_valid | input | 1 | Data byte valid |
| in_ready | output | 1 | Byte accepted this cycle when high |
| in_data | input | 8 | Data byte |
| commit | input | 1 | Stop-condition pulse; starts the array update |
| wp | input | 1 | Write-protect level |
| wr_valid | output | 1 | Array write request |
| wr_ready | input | 1 | Array accepts the write |
| wr_addr | output | 13 | Array write address |
| wr_data | output | 8 | Array write data |
| ptr | output | 13 | Internal address pointer after a write |
| busy | output | 1 | Flush in progress |

## Verification
Several properties are checked on every cycle by the assertions. The write request is held stable under stall, and writes within one flush go to strictly rising offsets in a fixed row. The pointer and the loaded address stay frozen while a flush runs, and no write request appears after write protect was seen. Other behaviour can only be shown by the bench's scenarios against its behavioural model: the exact pointer values for short, wrapping, full and overfull pages, the last-byte-wins rule, and that unwritten locations in a page are left untouched.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {PW_IDLE = 1'b0, PW_FLUSH = 1'b1} pw_state_e;

  function automatic logic [12:0] pw_next_ptr(input logic [12:0] base,
                                              input logic [5:0]  cnt,
                                              input int          page_bits);
    logic [12:0] r;
    logic [12:0] pmask;
    pmask = 13'((1 << page_bits) - 1);
    if (cnt == 6'd0 || int'(cnt) >= (1 << page_bits)) r = base;
    else r = (base & ~pmask) | ((base + 13'(cnt)) & pmask);
    return r;
  endfunction
endpackage

// File: rtl/pwb_capture.sv
module pwb_capture #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 5,
  parameter int DATA_W    = 8,
  localparam int PAGE     = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic                 clr,
  input  logic                 start,
  input  logic                 addr_vld,
  input  logic [ADDR_W-1:0]    addr_in,
  input  logic                 byte_fire,
  input  logic [DATA_W-1:0]    byte_data,
  input  logic                 wp,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic [PAGE-1:0]      mask,
  output logic [ADDR_W-1:0]    base,
  output logic [PAGE_BITS:0]   count,
  output logic                 wp_seen
);
  logic [DATA_W-1:0]    store [PAGE];
  logic [PAGE_BITS-1:0] off_q;

  assign rd_data = store[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask    <= '0;
      base    <= '0;
      count   <= '0;
      wp_seen <= 1'b0;
      off_q   <= '0;
    end else if (clr) begin
      mask    <= '0;
      count   <= '0;
      wp_seen <= 1'b0;
    end else if (!hold) begin
      wp_seen <= (start ? 1'b0 : wp_seen) | wp;
      if (start) begin
        mask  <= '0;
        count <= '0;
      end else if (byte_fire) begin
        mask[off_q] <= 1'b1;
        if (count != (PAGE_BITS+1)'(PAGE)) count <= count + 1'b1;
      end
      if (addr_vld) off_q <= addr_in[PAGE_BITS-1:0];
      else if (byte_fire && !start) off_q <= off_q + 1'b1;
      if (addr_vld) base <= addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && !hold && !start && byte_fire) store[off_q] <= byte_data;
  end

  // R5
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(base));
endmodule

// File: rtl/pwb_flush.sv
module pwb_flush #(
  parameter int PAGE_BITS = 5,
  localparam int PAGE     = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [PAGE-1:0]      mask,
  input  logic                 wr_ready,
  output logic                 busy,
  output logic [PAGE_BITS-1:0] idx,
  output logic                 wr_valid,
  output logic                 done
);
  import pwb_pkg::*;
  pw_state_e st;
  logic adv;

  assign busy     = (st == PW_FLUSH);
  assign wr_valid = busy && mask[idx];
  assign adv      = busy && (!mask[idx] || wr_ready);
  assign done     = adv && (idx == PAGE_BITS'(PAGE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= PW_IDLE;
      idx <= '0;
    end else if (!busy) begin
      if (go) begin
        st  <= PW_FLUSH;
        idx <= '0;
      end
    end else if (adv) begin
      idx <= idx + 1'b1;
      if (done) st <= PW_IDLE;
    end
  end

  // R3
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (!wr_valid || idx > $past(idx)));
endmodule

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 defer,
  input  logic                 done,
  input  logic                 busy,
  input  logic [ADDR_W-1:0]    base,
  input  logic [PAGE_BITS:0]   count,
  output logic [ADDR_W-1:0]    ptr
);
  localparam logic [ADDR_W-1:0] OFF_M = ADDR_W'((1 << PAGE_BITS) - 1);
  localparam int PAGE = 1 << PAGE_BITS;
  logic [ADDR_W-1:0] calc, pend_q;

  always_comb begin
    if (count == '0 || int'(count) >= PAGE) calc = base;
    else calc = (base & ~OFF_M) | ((base + ADDR_W'(count)) & OFF_M);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= '0;
      pend_q <= '0;
    end else if (done) begin
      ptr <= pend_q;
    end else if (take) begin
      if (defer) pend_q <= calc;
      else       ptr    <= calc;
    end
  end

  // R12
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(ptr));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W    = 13,
  parameter int PAGE_BITS = 5,
  parameter int DATA_W    = 8,
  localparam int PAGE     = 1 << PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              commit,
  input  logic              wp,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              busy
);
  logic [PAGE-1:0]      mask;
  logic [ADDR_W-1:0]    base;
  logic [PAGE_BITS:0]   count;
  logic                 wp_seen, take, go, done, mask_clr;
  logic [PAGE_BITS-1:0] idx;

  assign in_ready = !busy;
  assign take     = commit && !busy;
  assign go       = take && !(wp_seen || wp) && (|mask);
  assign mask_clr = (take && !go) || done;
  assign wr_addr  = {base[ADDR_W-1:PAGE_BITS], idx};

  pwb_capture #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .hold(busy), .clr(mask_clr), .start(bus_start),
    .addr_vld(addr_vld), .addr_in(addr_in), .byte_fire(in_valid && in_ready),
    .byte_data(in_data), .wp(wp), .rd_idx(idx), .rd_data(wr_data),
    .mask(mask), .base(base), .count(count), .wp_seen(wp_seen));

  pwb_flush #(.PAGE_BITS(PAGE_BITS)) u_flush (
    .clk(clk), .rst_n(rst_n), .go(go), .mask(mask), .wr_ready(wr_ready),
    .busy(busy), .idx(idx), .wr_valid(wr_valid), .done(done));

  pwb_pointer #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .take(take), .defer(go), .done(done),
    .busy(busy), .base(base), .count(count), .ptr(ptr));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wp_seen);
  // R1
  row_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |-> (wr_addr[ADDR_W-1:PAGE_BITS] == $past(wr_addr[ADDR_W-1:PAGE_BITS])));
endmodule

// File: tb/sim_page_write_buffer.sv
module sim_page_write_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_start = 0, addr_vld = 0, in_valid = 0, commit = 0, wp = 0, wr_ready = 1;
  logic [12:0] addr_in = '0;
  logic [7:0]  in_data = '0;
  logic in_ready, wr_valid, busy;
  logic [12:0] wr_addr, ptr;
  logic [7:0]  wr_data;
  int n_chk = 0, n_fail = 0, cyc_n = 0;
  bit bp_en = 0, finished = 0;
  logic [7:0] dmem [int];

  // reference model state
  bit m_busy; int m_idx, m_off, m_cnt; bit [31:0] m_mask; bit m_wps;
  logic [7:0] m_buf [32]; logic [12:0] m_base, m_ptr, m_pend;

  always #10 clk = ~clk;

  page_write_buffer u0 (.clk, .rst_n, .bus_start, .addr_vld, .addr_in, .in_valid,
    .in_ready, .in_data, .commit, .wp, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .ptr, .busy);

  function automatic logic [12:0] rule_ptr(logic [12:0] b, int c);
    if (c == 0 || c >= 32) return b;
    return {b[12:5], 5'((int'(b[4:0]) + c) % 32)};
  endfunction

  always @(posedge clk) begin
    cyc_n++;
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_off = 0; m_cnt = 0; m_mask = 0; m_wps = 0;
      m_base = 0; m_ptr = 0; m_pend = 0;
    end else begin
      if (wr_valid && wr_ready) dmem[int'(wr_addr)] = wr_data;
      if (m_busy) begin
        if (!m_mask[m_idx] || wr_ready) begin
          if (m_idx == 31) begin
            m_busy = 0; m_ptr = m_pend; m_mask = 0; m_cnt = 0; m_wps = 0;
          end
          m_idx = (m_idx + 1) % 32;
        end
      end else if (commit) begin
        m_pend = rule_ptr(m_base, m_cnt);
        if (m_wps || wp || m_mask == 0) begin
          m_ptr = m_pend; m_mask = 0; m_cnt = 0; m_wps = 0;
        end else begin
          m_wps = 0; m_busy = 1; m_idx = 0;
        end
      end else begin
        if (bus_start) begin m_mask = 0; m_cnt = 0; m_wps = 0; end
        m_wps = m_wps | wp;
        if (in_valid && !bus_start) begin
          m_buf[m_off] = in_data; m_mask[m_off] = 1'b1;
          m_off = (m_off + 1) % 32; if (m_cnt < 32) m_cnt++;
        end
        if (addr_vld) begin m_base = addr_in; m_off = int'(addr_in[4:0]); end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev; ev = m_busy && m_mask[m_idx];
      chk(wr_valid == ev, "R3 wr_valid", wr_valid, ev);
      if (ev) begin
        chk(wr_addr == {m_base[12:5], 5'(m_idx)}, "R1 wr_addr", wr_addr, {m_base[12:5], 5'(m_idx)});
        chk(wr_data == m_buf[m_idx], "R2 wr_data", wr_data, m_buf[m_idx]);
      end
      chk(in_ready == !m_busy, "R5 in_ready", in_ready, !m_busy);
      chk(ptr == m_ptr, "R12 ptr", ptr, m_ptr);
    end
    if (bp_en) wr_ready = (cyc_n % 3) != 0; else wr_ready = 1'b1;
  end

  task automatic cyc(); @(negedge clk); endtask
  task automatic begin_xfer(logic [12:0] a);
    bus_start = 1; cyc(); bus_start = 0;
    addr_vld = 1; addr_in = a; cyc(); addr_vld = 0;
  endtask
  task automatic put(logic [7:0] d);
    in_valid = 1; in_data = d; cyc(); in_valid = 0;
  endtask
  task automatic stop_and_wait();
    commit = 1; cyc(); commit = 0;
    while (!in_ready) cyc();
    cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    // R11 reset state
    chk(ptr == 0, "R11 ptr", ptr, 0);
    chk(wr_valid == 0, "R11 wr_valid", wr_valid, 0);
    chk(in_ready == 1 && busy == 0, "R11 in_ready/busy", {in_ready, busy}, 2'b10);

    // R1 R6 short page write, neighbours untouched (R3)
    dmem.delete();
    begin_xfer(13'h0123);
    for (int k = 0; k < 4; k++) put(8'hA0 + 8'(k));
    stop_and_wait();
    chk(dmem.num() == 4, "R3 count", dmem.num(), 4);
    for (int k = 0; k < 4; k++)
      chk(dmem.exists(8'h23 + 32'h100 + k) && dmem[32'h123 + k] == 8'hA0 + 8'(k), "R1 data", k, k);
    chk(!dmem.exists(32'h122) && !dmem.exists(32'h127), "R3 untouched", 0, 0);
    chk(ptr == 13'h0127, "R6 ptr", ptr, 13'h0127);

    // R2 R6 wrap inside page
    dmem.delete();
    begin_xfer(13'h1FFE);
    for (int k = 0; k < 5; k++) put(8'hB0 + 8'(k));
    stop_and_wait();
    chk(dmem.exists(32'h1FE0) && dmem[32'h1FE0] == 8'hB2, "R2 wrap", dmem.exists(32'h1FE0), 1);
    chk(dmem.exists(32'h1FE2) && dmem[32'h1FE2] == 8'hB4, "R2 wrap end", 0, 0);
    chk(ptr == 13'h1FE3, "R6 wrap ptr", ptr, 13'h1FE3);

    // R8 single byte at offset 31
    dmem.delete();
    begin_xfer(13'h005F);
    put(8'hC0);
    stop_and_wait();
    chk(dmem.num() == 1 && dmem.exists(32'h5F), "R8 write", dmem.num(), 1);
    chk(ptr == 13'h0040, "R8 ptr", ptr, 13'h0040);

    // R2 R7 R4 overfull page under back-pressure
    dmem.delete();
    bp_en = 1;
    begin_xfer(13'h0A45);
    for (int k = 0; k < 34; k++) put(8'(k));
    stop_and_wait();
    bp_en = 0;
    chk(dmem.num() == 32, "R7 count", dmem.num(), 32);
    chk(dmem[32'h0A45] == 8'd32 && dmem[32'h0A46] == 8'd33, "R2 last wins", dmem[32'h0A45], 32);
    chk(dmem[32'h0A44] == 8'd31, "R2 offset4", dmem[32'h0A44], 31);
    chk(ptr == 13'h0A45, "R7 ptr", ptr, 13'h0A45);

    // R9 write protect pulse mid transfer
    dmem.delete();
    begin_xfer(13'h0200);
    put(8'h11); wp = 1; put(8'h22); wp = 0; put(8'h33);
    stop_and_wait();
    chk(dmem.num() == 0, "R9 no write", dmem.num(), 0);
    chk(ptr == 13'h0203, "R9 ptr", ptr, 13'h0203);

    // R10 address-only transfer
    begin_xfer(13'h1234);
    stop_and_wait();
    chk(dmem.num() == 0, "R10 no write", dmem.num(), 0);
    chk(ptr == 13'h1234, "R10 ptr", ptr, 13'h1234);

    // R5 pulses during flush are ignored
    dmem.delete();
    bp_en = 1;
    begin_xfer(13'h0300);
    put(8'h44); put(8'h55);
    commit = 1; cyc(); commit = 0;
    bus_start = 1; addr_vld = 1; addr_in = 13'h0777; commit = 1; in_valid = 1; in_data = 8'hEE;
    cyc();
    bus_start = 0; addr_vld = 0; commit = 0; in_valid = 0;
    while (!in_ready) cyc();
    cyc(); bp_en = 0;
    chk(dmem.num() == 2 && dmem[32'h301] == 8'h55, "R5 writes", dmem.num(), 2);
    chk(ptr == 13'h0302, "R5 ptr", ptr, 13'h0302);
    commit = 1; cyc(); commit = 0; cyc();
    chk(ptr == 13'h0300, "R5 base kept", ptr, 13'h0300);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule